// File: doc/BRIEF.md
# Serial Transmitter with Ninth Data Bit

This block serialises characters onto a single asynchronous line. Each character is framed by a low start bit and a high stop bit. The payload is eight data bits, or nine in the wide mode, sent least significant bit first. In the wide mode the extra bit comes from a separate ninth-bit control input. The block samples that input only at the moment a byte is accepted. A software-held value can therefore serve as a fixed mark or space parity bit for every character until it is changed. The line can be inverted as a whole, and a break command sends a long low period. In single-wire half-duplex operation, a direction control turns the pin driver on or off.

Bytes arrive over a valid/ready stream. A one-entry holding stage sits behind `wr_ready`, so the producer can queue the next character while the current one is shifting. Once that entry is full, `wr_ready` stays low until the shifter takes the byte, which happens at the baud tick that ends the current stop bit. A write offered while `wr_ready` is low is not taken and must be held until it is accepted. Bit timing comes from an external one-cycle `baud_tick` pulse, and every line transition follows a tick.

Top module: `uart9_tx`

## Requirements
- R1: With `nine_mode`=0 and `invert`=0, a character is sent as one start bit at 0, then `wr_data` bit 0 through bit 7, then one stop bit at 1. Each bit lasts one baud tick interval, and the line rests at 1 between characters.
- R2: With `nine_mode`=1, the ninth data bit is sent right after data bit 7 and before the stop bit.
- R3: The ninth bit sent is the value `ninth_bit` had in the cycle its byte was accepted. Later changes of `ninth_bit` do not alter that character, and the same input value is reused for each later byte until it changes.
- R4: With `invert`=1, every line level is the complement of its R1/R2/R5 value, covering idle, start, data, stop and break.
- R5: A one-cycle `break_req` pulse sends a low period of exactly 10 bit times when `nine_mode`=0, or 11 bit times when `nine_mode`=1. A high stop bit follows it.
- R6: One accepted byte is held while another character shifts. While it is held, `wr_ready` is 0. It starts with no idle gap, at the tick that ends the current stop bit.
- R7: `line_oe` is 0 exactly when `loop_en`=1, `rx_from_pin`=1 and `dir_out`=0, and is 1 otherwise.
- R8: `tx_idle` is 1 only when no character or break is shifting, pending or buffered. It drops the cycle after a byte is accepted and returns the cycle after the final stop bit ends.
- R9: After reset, `line_out`=1 (with `invert`=0), `line_oe`=1, `tx_idle`=1 and `wr_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_ready | output | 1 | Holding stage can take a byte |
| wr_data | input | 8 | Byte to send |
| ninth_bit | input | 1 | Ninth data bit, captured with each accepted byte |
| nine_mode | input | 1 | 1 selects nine data bits |
| invert | input | 1 | 1 inverts every line level |
| loop_en | input | 1 | Loop mode enable |
| rx_from_pin | input | 1 | Receiver sourced from the transmit pin (single-wire when set with `loop_en`) |
| dir_out | input | 1 | Single-wire pin direction, 1 = output |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| break_req | input | 1 | One-cycle break command |
| line_out | output | 1 | Serial line value |
| line_oe | output | 1 | Pin driver enable |
| tx_idle | output | 1 | Transmitter has nothing to send |

## Verification
A new line level appears in the cycle after the clock edge that samples `baud_tick` high. The bench therefore reads `line_out` at the falling edge of each tick cycle, which gives the level of the bit that the tick is about to end. `wr_ready` and `tx_idle` change one cycle after the accepting edge, and the bench checks them one step after that edge. `line_oe` depends only on the mode inputs within the same cycle, so it is checked a fraction of a cycle after those inputs change. Break length is measured as a count of consecutive low tick samples.

// File: rtl/uart9_pkg.sv
`timescale 1ns/1ps
package uart9_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_BREAK = 3'd4
  } tx_state_e;
endpackage

// File: rtl/u9_hold.sv
`timescale 1ns/1ps
// One-entry holding stage in front of the shifter.
module u9_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         pop
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/u9_shift.sv
`timescale 1ns/1ps
// Frame sequencer: start, data (8 or 9), stop, and break.
module u9_shift
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            nine_mode,
  input  logic            ld_valid,
  input  logic [DATA_W:0] ld_data,
  output logic            ld_pop,
  input  logic            brk_req,
  output logic            line_raw,
  output logic            busy
);
  localparam int FW = DATA_W + 1;
  localparam int CW = $clog2(DATA_W + 3);
  localparam logic [CW-1:0] LAST_NARROW = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_WIDE   = CW'(DATA_W);
  localparam logic [CW-1:0] BRK_NARROW  = CW'(DATA_W + 1);
  localparam logic [CW-1:0] BRK_WIDE    = CW'(DATA_W + 2);

  tx_state_e      state_q;
  logic [FW-1:0]  sh_q;
  logic [CW-1:0]  cnt_q;
  logic           brk_pend_q;
  logic [CW-1:0]  last_bit;
  logic [CW-1:0]  brk_last;
  logic           at_boundary;

  assign last_bit    = nine_mode ? LAST_WIDE : LAST_NARROW;
  assign brk_last    = nine_mode ? BRK_WIDE : BRK_NARROW;
  assign at_boundary = (state_q == ST_IDLE) || (state_q == ST_STOP);
  assign ld_pop      = tick && at_boundary && ld_valid;
  assign busy        = (state_q != ST_IDLE) || brk_pend_q;

  always_comb begin
    case (state_q)
      ST_START, ST_BREAK: line_raw = 1'b0;
      ST_DATA:            line_raw = sh_q[0];
      default:            line_raw = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      brk_pend_q <= 1'b0;
    end else begin
      if (tick) begin
        case (state_q)
          ST_IDLE, ST_STOP: begin
            if (ld_valid) begin
              state_q <= ST_START;
              sh_q    <= ld_data;
            end else if (brk_pend_q) begin
              state_q    <= ST_BREAK;
              cnt_q      <= '0;
              brk_pend_q <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_START: begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if (cnt_q == last_bit) state_q <= ST_STOP;
            else                   cnt_q   <= cnt_q + 1'b1;
          end
          ST_BREAK: begin
            if (cnt_q == brk_last) state_q <= ST_STOP;
            else                   cnt_q   <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
      if (brk_req) brk_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/u9_pad.sv
`timescale 1ns/1ps
// Output polarity and pin direction.
module u9_pad (
  input  logic raw,
  input  logic invert,
  input  logic loop_en,
  input  logic rx_from_pin,
  input  logic dir_out,
  output logic line_out,
  output logic line_oe
);
  logic single_wire;

  assign single_wire = loop_en && rx_from_pin;
  assign line_out    = raw ^ invert;
  assign line_oe     = !single_wire || dir_out;
endmodule

// File: rtl/uart9_tx.sv
`timescale 1ns/1ps
module uart9_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ninth_bit,
  input  logic              nine_mode,
  input  logic              invert,
  input  logic              loop_en,
  input  logic              rx_from_pin,
  input  logic              dir_out,
  input  logic              baud_tick,
  input  logic              break_req,
  output logic              line_out,
  output logic              line_oe,
  output logic              tx_idle
);
  localparam int FW = DATA_W + 1;

  logic          hold_valid;
  logic [FW-1:0] hold_data;
  logic          hold_pop;
  logic          raw;
  logic          shift_busy;

  u9_hold #(.W(FW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (wr_valid),
    .in_ready (wr_ready),
    .in_data  ({ninth_bit, wr_data}),
    .out_valid(hold_valid),
    .out_data (hold_data),
    .pop      (hold_pop)
  );

  u9_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .nine_mode(nine_mode),
    .ld_valid (hold_valid),
    .ld_data  (hold_data),
    .ld_pop   (hold_pop),
    .brk_req  (break_req),
    .line_raw (raw),
    .busy     (shift_busy)
  );

  u9_pad u_pad (
    .raw        (raw),
    .invert     (invert),
    .loop_en    (loop_en),
    .rx_from_pin(rx_from_pin),
    .dir_out    (dir_out),
    .line_out   (line_out),
    .line_oe    (line_oe)
  );

  assign tx_idle = !shift_busy && !hold_valid;
endmodule

// File: rtl/uart9_tx_chk.sv
`timescale 1ns/1ps
module uart9_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic invert,
  input logic loop_en,
  input logic rx_from_pin,
  input logic dir_out,
  input logic baud_tick,
  input logic line_out,
  input logic line_oe,
  input logic tx_idle
);
  // R1: line levels move only after a sampled baud tick (or a polarity change)
  assert_line_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> ($stable(line_out) || !$stable(invert)));

  // R4: an idle transmitter shows the idle level for the current polarity
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (line_out == !invert));

  // R6: a full holding stage empties only at a baud tick
  assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !baud_tick) |=> !wr_ready);

  // R7: the driver is off only in single-wire mode with input direction
  assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> (loop_en && rx_from_pin && !dir_out));

  // R8: an accepted byte makes the transmitter busy on the next cycle
  assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !tx_idle);
endmodule

bind uart9_tx uart9_tx_chk u_chk (.*);

// File: tb/uart9_tx_test.sv
`timescale 1ns/1ps
module uart9_tx_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       ninth_bit = 1'b0;
  logic       nine_mode = 1'b0;
  logic       invert = 1'b0;
  logic       loop_en = 1'b0;
  logic       rx_from_pin = 1'b0;
  logic       dir_out = 1'b0;
  logic       baud_tick = 1'b0;
  logic       break_req = 1'b0;
  logic       line_out;
  logic       line_oe;
  logic       tx_idle;

  int n_checks = 0;
  int n_fail = 0;
  int tick_div = 0;

  always #4 clk = ~clk;

  uart9_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .ninth_bit(ninth_bit), .nine_mode(nine_mode),
    .invert(invert), .loop_en(loop_en), .rx_from_pin(rx_from_pin),
    .dir_out(dir_out), .baud_tick(baud_tick), .break_req(break_req),
    .line_out(line_out), .line_oe(line_oe), .tx_idle(tx_idle)
  );

  // baud tick: one cycle high every DIV cycles, changed at falling edges
  initial forever begin
    @(negedge clk);
    tick_div  = (tick_div == DIV - 1) ? 0 : tick_div + 1;
    baud_tick = (tick_div == 0);
  end

  // nine, inv, ninth, data
  localparam logic [10:0] VECS [0:5] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'h81},
    {1'b1, 1'b0, 1'b0, 8'hFF},
    {1'b1, 1'b1, 1'b1, 8'h5A}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic tick_sample(output logic v);
    do begin
      @(negedge clk);
      #1;
    end while (!baud_tick);
    v = line_out;
  endtask

  task automatic recv(input int nbits, input int maxwait, input logic inv,
                      output logic [8:0] bits, output logic start_ok, output logic stop_v);
    logic v;
    int   w;
    w = 0;
    tick_sample(v);
    while ((v ^ inv) !== 1'b0 && w < maxwait) begin
      w++;
      tick_sample(v);
    end
    start_ok = ((v ^ inv) === 1'b0);
    bits = '0;
    for (int i = 0; i < nbits; i++) begin
      tick_sample(v);
      bits[i] = v ^ inv;
    end
    tick_sample(v);
    stop_v = v ^ inv;
  endtask

  task automatic break_len(input logic inv, output int lows, output logic after_v);
    logic v;
    int   w;
    @(negedge clk);
    break_req = 1'b1;
    @(negedge clk);
    break_req = 1'b0;
    w = 0;
    tick_sample(v);
    while ((v ^ inv) !== 1'b0 && w < 20) begin
      w++;
      tick_sample(v);
    end
    lows = 0;
    while ((v ^ inv) === 1'b0 && lows < 30) begin
      lows++;
      tick_sample(v);
    end
    after_v = v ^ inv;
  endtask

  initial begin
    logic [8:0] bits;
    logic [8:0] bits_b;
    logic       st_ok, stp, st_ok_b, stp_b;
    int         lows;
    logic       after_v;

    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 line_out", {31'b0, line_out}, 32'd1);
    check("R9 line_oe", {31'b0, line_oe}, 32'd1);
    check("R9 tx_idle", {31'b0, tx_idle}, 32'd1);
    check("R9 wr_ready", {31'b0, wr_ready}, 32'd1);

    // vector table: R1 (8-bit), R2 (9-bit), R4 (inverted)
    foreach (VECS[k]) begin
      string req;
      int    nb;
      logic  inv;
      nine_mode = VECS[k][10];
      invert    = VECS[k][9];
      ninth_bit = VECS[k][8];
      inv       = VECS[k][9];
      nb        = VECS[k][10] ? 9 : 8;
      req       = VECS[k][9] ? "R4" : (VECS[k][10] ? "R2" : "R1");
      send(VECS[k][7:0]);
      @(negedge clk);
      check({req, " busy after write R8"}, {31'b0, tx_idle}, 32'd0);
      recv(nb, 20, inv, bits, st_ok, stp);
      check({req, " start"}, {31'b0, st_ok}, 32'd1);
      check({req, " data"}, {23'b0, bits},
            {23'b0, (VECS[k][10] ? VECS[k][8] : 1'b0), VECS[k][7:0]});
      check({req, " stop"}, {31'b0, stp}, 32'd1);
      @(negedge clk);
      check({req, " idle level"}, {31'b0, line_out}, {31'b0, !inv});
      check({req, " idle again R8"}, {31'b0, tx_idle}, 32'd1);
    end

    // R3: ninth bit captured at acceptance, then reused
    nine_mode = 1'b1;
    invert    = 1'b0;
    ninth_bit = 1'b1;
    send(8'h12);
    ninth_bit = 1'b0;
    recv(9, 20, 1'b0, bits, st_ok, stp);
    check("R3 captured ninth", {31'b0, bits[8]}, 32'd1);
    check("R3 captured byte", {24'b0, bits[7:0]}, 32'h12);
    send(8'h34);
    recv(9, 20, 1'b0, bits, st_ok, stp);
    check("R3 new ninth", {31'b0, bits[8]}, 32'd0);
    send(8'h56);
    recv(9, 20, 1'b0, bits, st_ok, stp);
    check("R3 reused ninth", {31'b0, bits[8]}, 32'd0);

    // R6: back-to-back characters
    nine_mode = 1'b0;
    repeat (8) @(negedge clk);
    fork
      begin
        send(8'hC3);
        send(8'h69);
        check("R6 ready low while held", {31'b0, wr_ready}, 32'd0);
      end
      begin
        recv(8, 20, 1'b0, bits, st_ok, stp);
        recv(8, 0, 1'b0, bits_b, st_ok_b, stp_b);
      end
    join
    check("R6 first byte", {23'b0, bits}, 32'hC3);
    check("R6 second starts with no gap", {31'b0, st_ok_b}, 32'd1);
    check("R6 second byte", {23'b0, bits_b}, 32'h69);
    check("R6 second stop", {31'b0, stp_b}, 32'd1);
    repeat (8) @(negedge clk);

    // R5: break lengths
    break_len(1'b0, lows, after_v);
    check("R5 break 8-bit length", lows, 32'd10);
    check("R5 stop after break", {31'b0, after_v}, 32'd1);
    repeat (8) @(negedge clk);
    nine_mode = 1'b1;
    break_len(1'b0, lows, after_v);
    check("R5 break 9-bit length", lows, 32'd11);
    repeat (8) @(negedge clk);
    nine_mode = 1'b0;
    invert    = 1'b1;
    break_len(1'b1, lows, after_v);
    check("R4 inverted break length", lows, 32'd10);
    check("R4 inverted stop after break", {31'b0, after_v}, 32'd1);
    repeat (8) @(negedge clk);
    check("R4 inverted idle", {31'b0, line_out}, 32'd0);
    invert = 1'b0;

    // R7: pin direction
    @(negedge clk);
    loop_en = 1'b1; rx_from_pin = 1'b1; dir_out = 1'b0;
    #1;
    check("R7 single-wire input", {31'b0, line_oe}, 32'd0);
    dir_out = 1'b1;
    #1;
    check("R7 single-wire output", {31'b0, line_oe}, 32'd1);
    rx_from_pin = 1'b0; dir_out = 1'b0;
    #1;
    check("R7 loop only", {31'b0, line_oe}, 32'd1);
    loop_en = 1'b0; rx_from_pin = 1'b1;
    #1;
    check("R7 pin source only", {31'b0, line_oe}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule